// File: doc/BRIEF.md
# Lane Writemask Generator

This block converts two encoded masking selections, one for the X operand and one for the Y operand of a vector multiply-accumulate unit, into per-lane enable masks. Each selection is a 2-bit mode and a 5-bit value. Both are taken from fixed fields of a 64-bit operand word. A 2-bit element-size input sets how many lanes a 64-byte register holds: 8, 16 or 32. Each mask is 32 bits wide. Only the low lane-count bits can be set.

There are four masking modes. The parity mode enables all lanes, the odd lanes, the even lanes, or no lanes. The single mode enables one lane by index. The leading mode enables a count of lanes from the bottom. The trailing mode enables a count of lanes from the top. In vector mode (operand bit 63 set) the Y selection is ignored and Y enables every lane. The masks pass through an optional output register. This register is present by default and adds one cycle of latency.

The datapath holds no state machine. The mode decode is an enumerated type with four named modes: `MSK_PARITY` (0), `MSK_SINGLE` (1), `MSK_LEAD` (2) and `MSK_TRAIL` (3). The only sequential element is the output register, which is cleared by reset and loads every cycle afterwards.

Top module: `lwm_writemask`

## Requirements
- R1: Element size 2'b00 gives 8 lanes, 2'b01 gives 16 lanes, 2'b10 gives 32 lanes, and 2'b11 is treated as 8 lanes.
- R2: Mode 0 with value 0 enables all lanes. Value 1 enables the odd-index lanes, value 2 enables the even-index lanes, and any other value enables none.
- R3: Mode 1 enables only the lane whose index equals the value. A value at or above the lane count gives an all-zero mask.
- R4: Mode 2 with value N, where 0 < N < lane count, enables lanes 0 to N-1.
- R5: Mode 3 with value N, where 0 < N < lane count, enables the top N lanes, from lane count minus N up to lane count minus 1.
- R6: In modes 2 and 3, a value of zero, or a value at or above the lane count, enables all lanes.
- R7: Mask bits at index lane count and above are always zero.
- R8: The X mode and value are read from operand bits 47:46 and 45:41. The Y mode and value are read from bits 38:37 and 36:32. All other bits except bit 63 have no effect.
- R9: When operand bit 63 is 1, the Y mask enables all lanes regardless of the Y fields, and the X mask still follows the X fields.
- R10: With the output register present (the default), the masks appear one clock after the inputs. Both masks are zero during reset (active-low, asynchronous).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_word | input | 64 | Operand word carrying the mode, value and vector fields |
| elem_sz | input | 2 | Element-size select (sets the lane count) |
| x_lane_en | output | 32 | X operand lane enable mask |
| y_lane_en | output | 32 | Y operand lane enable mask |

## Verification
Two functions can act in the same cycle: the vector-mode override on the Y mask and the normal decode of the X fields. The bench provokes this by setting bit 63 together with a restrictive X selection and non-trivial Y fields. In that same registered cycle, it checks that Y is the full lane set and that X still follows its own mode. A second overlap is element-size truncation combined with out-of-range counts. In that case the count saturation and the clearing of high lanes must agree in the same result.

// File: rtl/lwm_pkg.sv
package lwm_pkg;

    typedef enum logic [1:0] {
        MSK_PARITY = 2'd0,
        MSK_SINGLE = 2'd1,
        MSK_LEAD   = 2'd2,
        MSK_TRAIL  = 2'd3
    } msk_mode_e;

    typedef enum logic [1:0] {
        ESZ_64   = 2'd0,
        ESZ_32   = 2'd1,
        ESZ_16   = 2'd2,
        ESZ_RSVD = 2'd3
    } elem_sz_e;

endpackage

// File: rtl/lwm_lane_count.sv
module lwm_lane_count
    import lwm_pkg::*;
#(
    parameter int MAX_LANES = 32,
    parameter int LCW       = $clog2(MAX_LANES + 1)
) (
    input  elem_sz_e              esz,
    output logic [LCW-1:0]        lanes,
    output logic [MAX_LANES-1:0]  lane_full
);

    logic [1:0] shift;

    always_comb begin
        unique case (esz)
            ESZ_16:   shift = 2'd0;
            ESZ_32:   shift = 2'd1;
            ESZ_64:   shift = 2'd2;
            ESZ_RSVD: shift = 2'd2;
        endcase
        lanes = LCW'(MAX_LANES) >> shift;
    end

    for (genvar i = 0; i < MAX_LANES; i++) begin : g_full
        assign lane_full[i] = (LCW'(i) < lanes);
    end

endmodule

// File: rtl/lwm_mask_core.sv
module lwm_mask_core
    import lwm_pkg::*;
#(
    parameter int MAX_LANES = 32,
    parameter int LCW       = $clog2(MAX_LANES + 1),
    parameter int VW        = 5
) (
    input  msk_mode_e             mode,
    input  logic [VW-1:0]         val,
    input  logic [LCW-1:0]        lanes,
    output logic [MAX_LANES-1:0]  mask
);

    localparam int CW = ((LCW > VW) ? LCW : VW) + 1;

    logic [CW-1:0] val_w;
    logic [CW-1:0] lanes_w;
    logic [CW-1:0] trail_base;
    logic          count_all;

    always_comb begin
        val_w      = CW'(val);
        lanes_w    = CW'(lanes);
        count_all  = (val_w == '0) || (val_w >= lanes_w);
        trail_base = lanes_w - val_w;
    end

    for (genvar i = 0; i < MAX_LANES; i++) begin : g_lane
        logic hit;
        always_comb begin
            unique case (mode)
                MSK_PARITY: hit = (val_w == CW'(0))
                               || ((val_w == CW'(1)) && ((i % 2) == 1))
                               || ((val_w == CW'(2)) && ((i % 2) == 0));
                MSK_SINGLE: hit = (CW'(i) == val_w);
                MSK_LEAD:   hit = count_all || (CW'(i) < val_w);
                MSK_TRAIL:  hit = count_all || (CW'(i) >= trail_base);
            endcase
            mask[i] = hit && (CW'(i) < lanes_w);
        end
    end

endmodule

// File: rtl/lwm_writemask.sv
module lwm_writemask
    import lwm_pkg::*;
#(
    parameter int VEC_BYTES     = 64,
    parameter int MIN_ELEM_BITS = 16,
    parameter int VW            = 5,
    parameter bit OUT_REG       = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [63:0] op_word,
    input  logic [1:0]  elem_sz,
    output logic [31:0] x_lane_en,
    output logic [31:0] y_lane_en
);

    localparam int MAX_LANES = VEC_BYTES * 8 / MIN_ELEM_BITS;
    localparam int LCW       = $clog2(MAX_LANES + 1);

    logic                 vec_mode;
    msk_mode_e            x_mode, y_mode_raw, y_mode;
    logic [VW-1:0]        x_val, y_val_raw, y_val;
    logic [LCW-1:0]       lanes;
    logic [MAX_LANES-1:0] lane_full;
    logic [MAX_LANES-1:0] x_nxt, y_nxt;
    logic                 unused_bits;

    assign vec_mode    = op_word[63];
    assign x_mode      = msk_mode_e'(op_word[47:46]);
    assign x_val       = op_word[45:41];
    assign y_mode_raw  = msk_mode_e'(op_word[38:37]);
    assign y_val_raw   = op_word[36:32];
    assign unused_bits = ^{op_word[62:48], op_word[40:39], op_word[31:0]};

    // Vector mode: steer Y to a leading count of zero, i.e. all lanes.
    assign y_mode = vec_mode ? MSK_LEAD : y_mode_raw;
    assign y_val  = vec_mode ? '0 : y_val_raw;

    lwm_lane_count #(.MAX_LANES(MAX_LANES), .LCW(LCW)) u_cnt (
        .esz       (elem_sz_e'(elem_sz)),
        .lanes     (lanes),
        .lane_full (lane_full)
    );

    lwm_mask_core #(.MAX_LANES(MAX_LANES), .LCW(LCW), .VW(VW)) u_xcore (
        .mode  (x_mode),
        .val   (x_val),
        .lanes (lanes),
        .mask  (x_nxt)
    );

    lwm_mask_core #(.MAX_LANES(MAX_LANES), .LCW(LCW), .VW(VW)) u_ycore (
        .mode  (y_mode),
        .val   (y_val),
        .lanes (lanes),
        .mask  (y_nxt)
    );

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                x_lane_en <= '0;
                y_lane_en <= '0;
            end else begin
                x_lane_en <= 32'(x_nxt);
                y_lane_en <= 32'(y_nxt);
            end
        end

        assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (x_lane_en == 32'($past(x_nxt))) && (y_lane_en == 32'($past(y_nxt))));
    end else begin : g_comb
        assign x_lane_en = 32'(x_nxt);
        assign y_lane_en = 32'(y_nxt);
    end

    assert_high_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((x_nxt & ~lane_full) == '0) && ((y_nxt & ~lane_full) == '0));

    assert_vector_y_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        vec_mode |-> (y_nxt == lane_full));

    assert_single_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (x_mode == MSK_SINGLE) |-> $onehot0(x_nxt));

    assert_parity_none_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((x_mode == MSK_PARITY) && (x_val > VW'(2))) |-> (x_nxt == '0));

    assert_count_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (((x_mode == MSK_LEAD) || (x_mode == MSK_TRAIL)) && (LCW'(x_val) >= lanes))
            |-> (x_nxt == lane_full));

endmodule

// File: tb/lwm_writemask_test.sv
module lwm_writemask_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] op_word = '0;
    logic [1:0]  elem_sz = '0;
    logic [31:0] x_lane_en, y_lane_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] x;
        logic [31:0] y;
        string       tag;
    } exp_t;

    exp_t q[$];
    exp_t e;

    always #2 clk = ~clk;

    lwm_writemask uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_word   (op_word),
        .elem_sz   (elem_sz),
        .x_lane_en (x_lane_en),
        .y_lane_en (y_lane_en)
    );

    function automatic int lane_cnt(logic [1:0] esz);
        case (esz)
            2'd1:    return 16;
            2'd2:    return 32;
            default: return 8;
        endcase
    endfunction

    function automatic logic [31:0] full_mask(int n);
        logic [31:0] m = '0;
        for (int i = 0; i < n; i++) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic [31:0] model(int n, logic [1:0] md, logic [4:0] v);
        logic [31:0] m = '0;
        int vi = int'(v);
        for (int i = 0; i < n; i++) begin
            case (md)
                2'd0: m[i] = (vi == 0) || (vi == 1 && i % 2 == 1) || (vi == 2 && i % 2 == 0);
                2'd1: m[i] = (i == vi);
                2'd2: m[i] = (vi == 0) || (vi >= n) || (i < vi);
                default: m[i] = (vi == 0) || (vi >= n) || (i >= n - vi);
            endcase
        end
        return m;
    endfunction

    function automatic logic [63:0] mk(logic vec, logic [1:0] xm, logic [4:0] xv,
                                       logic [1:0] ym, logic [4:0] yv, logic [63:0] junk);
        logic [63:0] o = junk;
        o[63]    = vec;
        o[47:46] = xm;
        o[45:41] = xv;
        o[38:37] = ym;
        o[36:32] = yv;
        return o;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic drive(logic [63:0] op, logic [1:0] esz, string tag);
        exp_t it;
        int n = lane_cnt(esz);
        @(negedge clk);
        op_word = op;
        elem_sz = esz;
        it.x   = model(n, op[47:46], op[45:41]);
        it.y   = op[63] ? full_mask(n) : model(n, op[38:37], op[36:32]);
        it.tag = tag;
        q.push_back(it);
    endtask

    // Monitor: results of the item driven at the previous negedge settle after this posedge.
    always @(posedge clk) begin
        #1;
        if (rst_n && q.size() > 0) begin
            e = q.pop_front();
            check(e.tag, x_lane_en, e.x, "x_mask");
            check(e.tag, y_lane_en, e.y, "y_mask");
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        op_word = mk(1'b0, 2'd0, 5'd0, 2'd0, 5'd0, 64'h0);
        repeat (3) @(negedge clk);
        check("R10", x_lane_en, 32'h0, "x_in_reset");
        check("R10", y_lane_en, 32'h0, "y_in_reset");
        rst_n = 1'b1;

        // R1: lane count per element size via leading count zero
        for (int s = 0; s < 4; s++)
            drive(mk(1'b0, 2'd2, 5'd0, 2'd3, 5'd0, 64'h0), 2'(s), "R1");

        // R2..R5: full sweep of modes and values at each lane count
        for (int s = 0; s < 3; s++)
            for (int md = 0; md < 4; md++)
                for (int v = 0; v < 32; v++)
                    drive(mk(1'b0, 2'(md), 5'(v), 2'(3 - md), 5'(v) ^ 5'h15, 64'h0), 2'(s),
                          md == 0 ? "R2" : md == 1 ? "R3" : md == 2 ? "R4" : "R5");

        // R6: saturated counts
        drive(mk(1'b0, 2'd2, 5'd20, 2'd3, 5'd16, 64'h0), 2'd0, "R6");
        drive(mk(1'b0, 2'd3, 5'd16, 2'd2, 5'd31, 64'h0), 2'd1, "R6");

        // R7: trailing lanes stop at the lane count
        drive(mk(1'b0, 2'd3, 5'd3, 2'd1, 5'd7, 64'h0), 2'd0, "R7");
        drive(mk(1'b0, 2'd0, 5'd1, 2'd0, 5'd2, 64'h0), 2'd3, "R7");

        // R8: unrelated bits set everywhere
        drive(mk(1'b0, 2'd1, 5'd5, 2'd2, 5'd3, 64'h7FFF_FF80_FFFF_FFFF), 2'd1, "R8");
        drive(mk(1'b0, 2'd3, 5'd9, 2'd0, 5'd1, 64'h5A5A_A5A5_3C3C_C3C3), 2'd2, "R8");

        // R9: vector mode overrides Y in the same cycle X is masked
        drive(mk(1'b1, 2'd1, 5'd3, 2'd1, 5'd3, 64'h0), 2'd0, "R9");
        drive(mk(1'b1, 2'd0, 5'd7, 2'd0, 5'd7, 64'h0), 2'd2, "R9");
        drive(mk(1'b1, 2'd3, 5'd4, 2'd2, 5'd1, 64'h0), 2'd1, "R9");

        // R10: back-to-back changes show one-cycle latency
        drive(mk(1'b0, 2'd1, 5'd0, 2'd1, 5'd7, 64'h0), 2'd0, "R10");
        drive(mk(1'b0, 2'd1, 5'd7, 2'd1, 5'd0, 64'h0), 2'd0, "R10");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule